// File: doc/BRIEF.md
# Multi-cycle processor datapath with cascaded select chains

This block is the storage and steering half of a five-state, 32-bit multi-cycle processor. It holds the program counter, the instruction register, the stack pointer and a 32-entry register file. A 29-bit control word, produced each cycle by an external sequencer, tells it which of these to load and which source each multiplexer chain passes on. The chains choose the next PC, both ALU operands, the register write address and data, the memory address and the memory write data. The ALU and the memory sit outside. Operands and the operation code leave on ports, and the ALU result and memory read data come back in.

Every chain is a fixed cascade of two-input selects, and each select is driven by one bit of the control word. The sequencer therefore assembles each instruction's behaviour from single bits. Push and pop take the stack pointer as the memory address. Link and pop use a fixed destination register. The instruction register is also visible on a port, so that the sequencer can decode it.

Top module: `dp_steer_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC and the instruction register clear to 0 and the stack pointer is set to 0x0000FFFF.
- R2: When control bit 4 is set, the instruction register captures `mem_rdata` at the clock edge; when it is clear, the register holds. The fields are decoded as rs = [25:21], rt = [20:16], rd = [15:11], shift amount = [10:6], immediate = [15:0] and jump field = [25:0].
- R3: Bit 6 is a read strobe. At the clock edge it latches two values: the register named by the first read address, and the register named by rt. The first read address is rs when bit 5 is 0 and register 0 when bit 5 is 1. Bit 7 writes the write data to the write address at the clock edge. Register 0 always reads as zero.
- R4: `alu_a` is the first latched read value when bit 9 is 0 and the stack pointer when bit 9 is 1.
- R5: `alu_b` comes from a four-stage chain. Stage a (bit 10) selects the constant 1 or the zero-extended shift amount. Stage b (bit 11) selects the zero-extended or the sign-extended immediate. Stage c (bit 12) passes stage b on 0 and stage a on 1. Stage d (bit 13) passes stage c on 0 and the second latched read value on 1.
- R6: `alu_op` equals control bits 19:14.
- R7: When bit 0 is set, the PC loads the next-PC chain result; otherwise it holds. Stage 1 (bit 1) selects the first read value on 0 and PC+1 on 1. Stage 2 (bit 2) passes stage 1 on 0 and the branch target PC+1+sext(imm) on 1. Stage 3 (bit 3) selects the jump address {PC+1[31:26], jump field} on 0 and stage 2 on 1.
- R8: When bit 8 is set, the stack pointer loads `alu_res` at the clock edge; otherwise it holds.
- R9: The write address comes from a three-stage chain. Stage 1 (bit 26) selects rd on 0 and rt on 1. Stage 2 (bit 27) selects register 0 on 0 and register 31 on 1. Stage 3 (bit 28) passes stage 2 on 0 and stage 1 on 1.
- R10: The write data comes from a three-stage chain. Stage 1 (bit 23) selects `alu_res` on 0 and `mem_rdata` on 1. Stage 2 (bit 24) passes stage 1 on 0 and {imm, 16'h0} on 1. Stage 3 (bit 25) selects PC+1 on 0 and stage 2 on 1.
- R11: `mem_addr` is built in two stages. Bit 20 selects `alu_res` on 0 and the stack pointer on 1. Bit 21 passes that result on 0 and the PC on 1.
- R12: `mem_wdata` is the second latched read value when bit 22 is 0 and the first when bit 22 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 29 | Control word from the sequencer |
| alu_res | input | 32 | Result returned by the external ALU |
| mem_rdata | input | 32 | Data read from memory |
| alu_a | output | 32 | First ALU operand |
| alu_b | output | 32 | Second ALU operand |
| alu_op | output | 6 | ALU operation code |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| instr | output | 32 | Current instruction register contents |

## Verification
A wrong PC, stack pointer or instruction register appears on `mem_addr` or `instr` in the cycle after the faulty edge, as soon as the select bits route that state out. A register-file fault stays hidden until a read strobe has fetched the entry. It then appears on `alu_a` or `alu_b` one cycle later. For that reason every entry is written and then read back. A wrong write-address or write-data select misplaces data silently, and it shows only when the affected register is read back.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int CW = 29;
  // control word bit positions, decoded by the sequencer
  localparam int C_PC_LD   = 0;
  localparam int C_PC_S1   = 1;
  localparam int C_PC_S2   = 2;
  localparam int C_PC_S3   = 3;
  localparam int C_IR_LD   = 4;
  localparam int C_RA1_SEL = 5;
  localparam int C_RF_RD   = 6;
  localparam int C_RF_WR   = 7;
  localparam int C_SP_LD   = 8;
  localparam int C_OP1_SEL = 9;
  localparam int C_OP2_S1  = 10;
  localparam int C_OP2_S2  = 11;
  localparam int C_OP2_S3  = 12;
  localparam int C_OP2_S4  = 13;
  localparam int C_ALU_LO  = 14;
  localparam int C_ALU_HI  = 19;
  localparam int C_MA_S1   = 20;
  localparam int C_MA_S2   = 21;
  localparam int C_MD_SEL  = 22;
  localparam int C_WD_S1   = 23;
  localparam int C_WD_S2   = 24;
  localparam int C_WD_S3   = 25;
  localparam int C_WA_S1   = 26;
  localparam int C_WA_S2   = 27;
  localparam int C_WA_S3   = 28;
endpackage

// File: rtl/dps_regfile.sv
module dps_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  logic [DW-1:0] mem [NREG];

  // read-first synchronous array, no reset on storage
  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wd;
    if (rd_en) begin
      rd1 <= (ra1 == '0) ? '0 : mem[ra1];
      rd2 <= (ra2 == '0) ? '0 : mem[ra2];
    end
  end

  // R3: index 0 always yields zero
  assert_zero_reg_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ra1 == '0) |=> (rd1 == '0));
endmodule

// File: rtl/dps_state_regs.sv
module dps_state_regs #(
  parameter int          DW       = 32,
  parameter logic [31:0] SP_RESET = 32'h0000_FFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_ld,
  input  logic          pc_s1,
  input  logic          pc_s2,
  input  logic          pc_s3,
  input  logic          ir_ld,
  input  logic          sp_ld,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] alu_res,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] pc_inc,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] sp
);
  localparam int JW = 26;
  localparam int IW = 16;

  logic [DW-1:0] imm_sx, br_tgt, jmp_tgt, nxt_a, nxt_b, nxt_pc;

  assign pc_inc  = pc + 1'b1;
  assign imm_sx  = {{(DW-IW){ir[IW-1]}}, ir[IW-1:0]};
  assign br_tgt  = pc_inc + imm_sx;
  assign jmp_tgt = {pc_inc[DW-1:JW], ir[JW-1:0]};
  assign nxt_a   = pc_s1 ? pc_inc : rs_val;
  assign nxt_b   = pc_s2 ? br_tgt : nxt_a;
  assign nxt_pc  = pc_s3 ? nxt_b  : jmp_tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
      sp <= SP_RESET[DW-1:0];
    end else begin
      if (pc_ld) pc <= nxt_pc;
      if (ir_ld) ir <= mem_rdata;
      if (sp_ld) sp <= alu_res;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && ir == '0 && sp == SP_RESET[DW-1:0]));
  assert_ir_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (ir == $past(mem_rdata)));
  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !pc_ld |=> $stable(pc));
  assert_sp_load_R8: assert property (@(posedge clk) disable iff (rst)
    sp_ld |=> (sp == $past(alu_res)));
endmodule

// File: rtl/dps_steer.sv
module dps_steer #(
  parameter int DW  = 32,
  parameter int AW  = 5
) (
  input  logic [28:0]   ctrl,
  input  logic [AW-1:0] rs,
  input  logic [AW-1:0] rt,
  input  logic [15:0]   imm,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] pc_inc,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] rv1,
  input  logic [DW-1:0] rv2,
  input  logic [DW-1:0] alu_res,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] ra1,
  output logic [AW-1:0] wa,
  output logic [DW-1:0] wd,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  output logic [DW-1:0] maddr,
  output logic [DW-1:0] mwdata
);
  import dps_pkg::*;

  localparam int IW = 16;
  localparam logic [AW-1:0] LINK_REG = AW'(31);

  logic [AW-1:0] rd, wa_a, wa_b;
  logic [DW-1:0] shamt_zx, imm_zx, imm_sx, imm_hi;
  logic [DW-1:0] ob_a, ob_b, ob_c, wd_a, wd_b, ma_a;

  assign rd       = imm[15:11];
  assign shamt_zx = {{(DW-5){1'b0}}, imm[10:6]};
  assign imm_zx   = {{(DW-IW){1'b0}}, imm};
  assign imm_sx   = {{(DW-IW){imm[IW-1]}}, imm};
  assign imm_hi   = {imm, {(DW-IW){1'b0}}};

  assign ra1 = ctrl[C_RA1_SEL] ? '0 : rs;

  assign op_a = ctrl[C_OP1_SEL] ? sp : rv1;

  assign ob_a = ctrl[C_OP2_S1] ? shamt_zx : DW'(1);
  assign ob_b = ctrl[C_OP2_S2] ? imm_sx   : imm_zx;
  assign ob_c = ctrl[C_OP2_S3] ? ob_a     : ob_b;
  assign op_b = ctrl[C_OP2_S4] ? rv2      : ob_c;

  assign wa_a = ctrl[C_WA_S1] ? rt       : rd;
  assign wa_b = ctrl[C_WA_S2] ? LINK_REG : '0;
  assign wa   = ctrl[C_WA_S3] ? wa_a     : wa_b;

  assign wd_a = ctrl[C_WD_S1] ? mem_rdata : alu_res;
  assign wd_b = ctrl[C_WD_S2] ? imm_hi    : wd_a;
  assign wd   = ctrl[C_WD_S3] ? wd_b      : pc_inc;

  assign ma_a  = ctrl[C_MA_S1] ? sp : alu_res;
  assign maddr = ctrl[C_MA_S2] ? pc : ma_a;

  assign mwdata = ctrl[C_MD_SEL] ? rv1 : rv2;
endmodule

// File: rtl/dp_steer_core.sv
module dp_steer_core #(
  parameter int          DW       = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] SP_RESET = 32'h0000_FFFF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [dps_pkg::CW-1:0] ctrl,
  input  logic [DW-1:0]         alu_res,
  input  logic [DW-1:0]         mem_rdata,
  output logic [DW-1:0]         alu_a,
  output logic [DW-1:0]         alu_b,
  output logic [5:0]            alu_op,
  output logic [DW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  output logic [DW-1:0]         instr
);
  import dps_pkg::*;

  localparam int AW = $clog2(NREG);

  logic [DW-1:0] pc, pc_inc, ir, sp, rv1, rv2, wd;
  logic [AW-1:0] ra1, wa;

  assign instr  = ir;
  assign alu_op = ctrl[C_ALU_HI:C_ALU_LO];

  dps_state_regs #(.DW(DW), .SP_RESET(SP_RESET)) u_state (
    .clk(clk), .rst(rst),
    .pc_ld(ctrl[C_PC_LD]), .pc_s1(ctrl[C_PC_S1]), .pc_s2(ctrl[C_PC_S2]),
    .pc_s3(ctrl[C_PC_S3]), .ir_ld(ctrl[C_IR_LD]), .sp_ld(ctrl[C_SP_LD]),
    .rs_val(rv1), .alu_res(alu_res), .mem_rdata(mem_rdata),
    .pc(pc), .pc_inc(pc_inc), .ir(ir), .sp(sp)
  );

  dps_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .rd_en(ctrl[C_RF_RD]), .wr_en(ctrl[C_RF_WR]),
    .ra1(ra1), .ra2(ir[16 +: AW]), .wa(wa), .wd(wd),
    .rd1(rv1), .rd2(rv2)
  );

  dps_steer #(.DW(DW), .AW(AW)) u_steer (
    .ctrl(ctrl), .rs(ir[21 +: AW]), .rt(ir[16 +: AW]), .imm(ir[15:0]),
    .pc(pc), .pc_inc(pc_inc), .sp(sp), .rv1(rv1), .rv2(rv2),
    .alu_res(alu_res), .mem_rdata(mem_rdata),
    .ra1(ra1), .wa(wa), .wd(wd), .op_a(alu_a), .op_b(alu_b),
    .maddr(mem_addr), .mwdata(mem_wdata)
  );
endmodule

// File: tb/tb_dp_steer_core.sv
module tb_dp_steer_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [28:0] ctrl = '0;
  logic [31:0] alu_res = '0, mem_rdata = '0;
  logic [31:0] alu_a, alu_b, mem_addr, mem_wdata, instr;
  logic [5:0]  alu_op;

  int total = 0, bad = 0;
  logic [31:0] exp_rf [32];
  logic [31:0] exp_pc, exp_sp, got;

  localparam logic [28:0] W_RF = 29'(1) << 7;

  always #5 clk = ~clk;

  dp_steer_core dut (.clk(clk), .rst(rst), .ctrl(ctrl), .alu_res(alu_res),
    .mem_rdata(mem_rdata), .alu_a(alu_a), .alu_b(alu_b), .alu_op(alu_op),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .instr(instr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [28:0] c);
    ctrl = c;
    @(posedge clk);
    #1;
    ctrl = '0;
  endtask

  task automatic peek(input logic [28:0] c);
    ctrl = c;
    #1;
  endtask

  task automatic load_ir(input logic [31:0] v);
    mem_rdata = v;
    tick(29'(1) << 4);
  endtask

  function automatic logic [31:0] mk(input int rs, input int rt, input int rd);
    return {6'h0, 5'(rs), 5'(rt), 5'(rd), 11'h0};
  endfunction

  task automatic read_reg(input int idx, output logic [31:0] v);
    load_ir(mk(idx, 0, 0));
    tick(29'(1) << 6);
    peek('0);
    v = alu_a;
  endtask

  function automatic logic [31:0] op2_model(input logic [3:0] s, input logic [31:0] ir, input logic [31:0] r2);
    logic [31:0] a, b, c;
    a = s[0] ? {27'h0, ir[10:6]} : 32'd1;
    b = s[1] ? {{16{ir[15]}}, ir[15:0]} : {16'h0, ir[15:0]};
    c = s[2] ? a : b;
    return s[3] ? r2 : c;
  endfunction

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1 reset state
    peek(29'(1) << 21); chk("R1 pc", mem_addr, 32'h0);
    peek(29'(1) << 20); chk("R1 sp", mem_addr, 32'h0000_FFFF);
    chk("R1 ir", instr, 32'h0);
    exp_pc = 0; exp_sp = 32'hFFFF;

    // R3/R9 sweep: write every register through rd address, alu data
    for (int k = 0; k < 32; k++) begin
      load_ir(mk(0, 0, k));
      chk("R2 ir load", instr, mk(0, 0, k));
      alu_res = 32'h1000_0000 + k * 32'h0001_0203;
      tick(W_RF | (29'(1) << 25) | (29'(1) << 28));
      exp_rf[k] = (k == 0) ? 32'h0 : alu_res;
    end
    // R2 hold when load bit clear
    mem_rdata = 32'hDEAD_BEEF;
    tick('0);
    chk("R2 ir hold", instr, mk(0, 0, 31));

    // R3/R4/R5/R12 read-back sweep
    for (int k = 0; k < 32; k++) begin
      load_ir(mk(k, 31 - k, 0));
      tick(29'(1) << 6);
      peek(29'(1) << 13);
      chk("R3 R4 rs read", alu_a, exp_rf[k]);
      chk("R3 R5 rt read", alu_b, exp_rf[31 - k]);
      peek('0);
      chk("R12 wdata rt", mem_wdata, exp_rf[31 - k]);
      peek(29'(1) << 22);
      chk("R12 wdata rs", mem_wdata, exp_rf[k]);
    end
    // R3 first read address forced to register 0
    load_ir(mk(5, 0, 0));
    tick((29'(1) << 6) | (29'(1) << 5));
    peek('0); chk("R3 r0 select", alu_a, 32'h0);
    // R4 stack pointer on operand 1
    peek(29'(1) << 9); chk("R4 sp operand", alu_a, exp_sp);

    // R5 operand-2 chain, all select combinations
    load_ir(mk(6, 9, 0) | 32'h0000_80C5);
    tick(29'(1) << 6);
    for (int s = 0; s < 16; s++) begin
      peek(29'(s) << 10);
      chk("R5 op2 chain", alu_b, op2_model(4'(s), mk(6, 9, 0) | 32'h0000_80C5, exp_rf[9]));
    end

    // R6 operation code pass-through
    for (int v = 0; v < 64; v++) begin
      peek(29'(v) << 14);
      chk("R6 alu_op", {26'h0, alu_op}, v);
    end

    // R11 memory address, all combinations
    alu_res = 32'h0BAD_0001;
    for (int s = 0; s < 4; s++) begin
      peek(29'(s) << 20);
      chk("R11 mem_addr", mem_addr, s[1] ? exp_pc : (s[0] ? exp_sp : alu_res));
    end

    // R8 stack pointer load and hold
    alu_res = 32'h0000_1234;
    tick(29'(1) << 8); exp_sp = 32'h1234;
    alu_res = 32'h5555_0000;
    tick('0);
    peek(29'(1) << 20); chk("R8 sp load/hold", mem_addr, exp_sp);

    // R9 write address: rt, then link register 31, then register 0
    load_ir(mk(0, 7, 9));
    alu_res = 32'hA0A0_0007;
    tick(W_RF | (29'(1) << 26) | (29'(1) << 28) | (29'(1) << 25));
    exp_rf[7] = alu_res;
    alu_res = 32'hB0B0_001F;
    tick(W_RF | (29'(1) << 27) | (29'(1) << 25));
    exp_rf[31] = alu_res;
    tick(W_RF | (29'(1) << 25));
    read_reg(7, got);  chk("R9 rt dest", got, exp_rf[7]);
    read_reg(9, got);  chk("R9 rd untouched", got, exp_rf[9]);
    read_reg(31, got); chk("R9 link dest", got, exp_rf[31]);
    read_reg(0, got);  chk("R9 r0 dest", got, 32'h0);

    // R10 write data: memory data, upper immediate, PC+1
    load_ir(mk(0, 0, 12) | 32'h0000_6000 | 32'h0000_0321);
    mem_rdata = 32'h1357_9BDF;
    tick(W_RF | (29'(1) << 23) | (29'(1) << 25) | (29'(1) << 28));
    read_reg(12, got); chk("R10 mem data", got, 32'h1357_9BDF);
    load_ir(mk(0, 0, 13) | 32'h0000_0155);
    tick(W_RF | (29'(1) << 24) | (29'(1) << 25) | (29'(1) << 28));
    read_reg(13, got); chk("R10 upper imm", got, {mk(0, 0, 13)[15:0] | 16'h0155, 16'h0});
    tick(W_RF | (29'(1) << 27));
    read_reg(31, got); chk("R10 pc+1", got, exp_pc + 1);

    // R7 next-PC chain
    for (int i = 0; i < 5; i++) begin
      tick((29'(1) << 0) | (29'(1) << 1) | (29'(1) << 3));
      exp_pc = exp_pc + 1;
      peek(29'(1) << 21); chk("R7 pc+1", mem_addr, exp_pc);
    end
    tick('0);
    peek(29'(1) << 21); chk("R7 pc hold", mem_addr, exp_pc);
    load_ir(32'h0000_FFFE);
    tick(29'h0000000F);
    exp_pc = exp_pc + 1 + 32'hFFFF_FFFE;
    peek(29'(1) << 21); chk("R7 branch", mem_addr, exp_pc);
    load_ir(32'h0800_0123);
    tick(29'(1) << 0);
    exp_pc = {exp_pc[31:26] + 6'h0, 26'h000_0123};
    peek(29'(1) << 21); chk("R7 jump", mem_addr, exp_pc);
    load_ir(mk(3, 0, 0));
    tick(29'(1) << 6);
    tick((29'(1) << 0) | (29'(1) << 3));
    exp_pc = exp_rf[3];
    peek(29'(1) << 21); chk("R7 register jump", mem_addr, exp_pc);

    // R1 reset again mid-run
    rst = 1'b1; tick('0); rst = 1'b0;
    peek(29'(1) << 21); chk("R1 pc re-reset", mem_addr, 32'h0);
    peek(29'(1) << 20); chk("R1 sp re-reset", mem_addr, 32'h0000_FFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule